// File: doc/BRIEF.md
# Reset Configuration Word Sequencer

This block runs the configuration phase that follows power-on reset in a system of several processing devices. While power-on reset is low it tracks two mode straps. At the release it keeps their value as the operating mode: configuration master, configuration slave, or standalone. It then holds the hard and soft reset outputs low for a fixed window of clock cycles. At the end of the window it presents a 32-bit configuration word and raises a single-cycle completion pulse.

As a slave, the device takes its word from bus writes whose target ID matches its own chip ID. If no write arrives, the word is zero. As master, the device reads words from an external memory through a request/valid handshake. The word at address 0 configures the master itself. The words at the following addresses are forwarded, one bus write each, to the slave devices in increasing chip-ID order. In standalone mode the window still runs, but the word is zero and the bus is not used.

Top module: `reset_cfg_sequencer`

## Requirements
- R1: The mode comes from {cfgSel, rstCfg} as held at the release of porRstN. 2'b00 selects master, 2'b01 selects slave, and 2'b10 or 2'b11 select standalone. Strap changes after the release have no effect until the next reset.
- R2: hardRstN and softRstN are low during reset and stay low through the 1023rd rising clock edge after the release. Both are high from the 1024th edge onward.
- R3: cfgDone is high for exactly one cycle: the first cycle in which hardRstN is high. cfgWord is zero before that cycle, and it holds the final word from that cycle on.
- R4: In slave mode, a write (wrEn high, wrId equal to chipId) inside the window is stored. A later matching write replaces the earlier one, and cfgWord is the last word stored.
- R5: In slave mode with no matching write, cfgWord is zero after the window.
- R6: A slave write whose wrId differs from chipId is ignored.
- R7: Writes after the window closes, and writes in master mode, leave cfgWord unchanged.
- R8: In standalone mode, cfgWord is zero after the window, and memReq and busWrEn never assert.
- R9: In master mode, the first memory request uses memAddr 0. The word returned with memValid becomes the master's own cfgWord.
- R10: In master mode, slave k (k = 0..NUM_SLAVES-1) gets the word read from memAddr k+1. It is delivered as one single-cycle busWrEn pulse with busWrId = FIRST_SLAVE_ID + k, in increasing k. After the last write, no further memory requests are made.
- R11: memReq and busWrEn are only high while hardRstN is low, and never in the same cycle.
- R12: Asserting porRstN low clears the mode, the cycle count and the word. From the next edge, hardRstN, softRstN, cfgDone, cfgWord, memReq and busWrEn are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low; mode is taken at its release |
| cfgSel | input | 1 | Mode strap, upper bit |
| rstCfg | input | 1 | Mode strap, lower bit |
| chipId | input | ID_W | This device's own ID |
| wrEn | input | 1 | Incoming configuration write strobe |
| wrId | input | ID_W | Target ID of the incoming write |
| wrData | input | WORD_W | Data of the incoming write |
| memReq | output | 1 | Memory read request (master) |
| memAddr | output | ADDR_W | Memory word index being read |
| memValid | input | 1 | Memory data valid, one cycle |
| memData | input | WORD_W | Memory read data |
| busWrEn | output | 1 | Outgoing configuration write strobe (master) |
| busWrId | output | ID_W | Target slave ID of the outgoing write |
| busWrData | output | WORD_W | Data of the outgoing write |
| hardRstN | output | 1 | Hard reset, active low |
| softRstN | output | 1 | Soft reset, active low |
| cfgDone | output | 1 | One-cycle pulse when the window closes |
| cfgWord | output | WORD_W | Latched configuration word |

## Verification
Several properties are checked on every cycle: the two reset outputs always agree; the memory request and the outgoing write never overlap and stay inside the window; outgoing writes are single pulses with in-range slave IDs; the done pulse lines up with the first cycle out of reset; the word is frozen once the window has closed; and a reset clears all outputs. Other behaviours only show up in the bench's scenarios: that the window is exactly 1024 edges long, that the mode is decoded from the straps and ignores later strap changes, that only the last matching slave write counts, and that the master forwards the right memory words in ID order.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [1:0] {
    MD_UNSET,
    MD_MASTER,
    MD_SLAVE,
    MD_STANDALONE
  } modeT;

  typedef enum logic [1:0] {
    MS_FETCH,
    MS_WRITE,
    MS_IDLE
  } mstT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSelf;    // own word from memory (master)
    logic loadSlave;   // own word from bus write (slave)
    logic captureFwd;  // word to forward to a slave (master)
    logic commit;      // window closes: publish word
  } strobeT;

  function automatic modeT decodeStraps(input logic [1:0] straps);
    case (straps)
      2'b00:   return MD_MASTER;
      2'b01:   return MD_SLAVE;
      default: return MD_STANDALONE;
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int ID_W           = 4,
  parameter int ADDR_W         = 4,
  parameter int WINDOW         = 1024,
  parameter int NUM_SLAVES     = 3,
  parameter int FIRST_SLAVE_ID = 1
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              cfgSel,
  input  logic              rstCfg,
  input  logic [ID_W-1:0]   chipId,
  input  logic              wrEn,
  input  logic [ID_W-1:0]   wrId,
  input  logic              memValid,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busWrEn,
  output logic [ID_W-1:0]   busWrId,
  output logic              hardRstN,
  output logic              softRstN,
  output logic              cfgDone,
  output strobeT            strobe
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW - 1);
  localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(NUM_SLAVES);

  logic [1:0]        strapSample;
  modeT              mode;
  mstT               mState;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] idx;
  logic              hardQ, softQ, doneQ;

  logic windowOpen, masterActive, fetchHit;

  assign windowOpen   = (mode != MD_UNSET) && (cnt != CNT_END);
  assign masterActive = windowOpen && (mode == MD_MASTER);
  assign fetchHit     = masterActive && (mState == MS_FETCH) && memValid;

  always_comb begin
    strobe            = '0;
    strobe.loadSelf   = fetchHit && (idx == '0);
    strobe.captureFwd = fetchHit && (idx != '0);
    strobe.loadSlave  = windowOpen && (mode == MD_SLAVE) && wrEn && (wrId == chipId);
    strobe.commit     = (mode != MD_UNSET) && (cnt == CNT_LAST);
  end

  assign memReq   = masterActive && (mState == MS_FETCH);
  assign memAddr  = idx;
  assign busWrEn  = masterActive && (mState == MS_WRITE);
  assign busWrId  = ID_W'(FIRST_SLAVE_ID + int'(idx) - 1);
  assign hardRstN = hardQ;
  assign softRstN = softQ;
  assign cfgDone  = doneQ;

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      strapSample <= {cfgSel, rstCfg};
      mode        <= MD_UNSET;
      mState      <= MS_FETCH;
      cnt         <= '0;
      idx         <= '0;
      hardQ       <= 1'b0;
      softQ       <= 1'b0;
      doneQ       <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (mode == MD_UNSET) mode <= decodeStraps(strapSample);

      if (cnt != CNT_END) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_LAST) begin
          hardQ <= 1'b1;
          softQ <= 1'b1;
          doneQ <= 1'b1;
        end
      end

      if (masterActive) begin
        case (mState)
          MS_FETCH: begin
            if (memValid) begin
              if (idx == '0) begin
                idx <= idx + ADDR_W'(1);
                if (NUM_SLAVES == 0) mState <= MS_IDLE;
              end else begin
                mState <= MS_WRITE;
              end
            end
          end
          MS_WRITE: begin
            idx    <= idx + ADDR_W'(1);
            mState <= (idx == IDX_LAST) ? MS_IDLE : MS_FETCH;
          end
          default: mState <= MS_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_seq_dp.sv
module cfg_seq_dp
  import cfg_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  strobeT            strobe,
  input  logic [WORD_W-1:0] memData,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] cfgWord
);

  logic [WORD_W-1:0] pending, nextPending, fwdReg, wordReg;

  // A write landing in the closing cycle still counts
  always_comb begin
    nextPending = pending;
    if (strobe.loadSelf)       nextPending = memData;
    else if (strobe.loadSlave) nextPending = wrData;
  end

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      pending <= '0;
      fwdReg  <= '0;
      wordReg <= '0;
    end else begin
      pending <= nextPending;
      if (strobe.captureFwd) fwdReg  <= memData;
      if (strobe.commit)     wordReg <= nextPending;
    end
  end

  assign busWrData = fwdReg;
  assign cfgWord   = wordReg;

endmodule

// File: rtl/reset_cfg_sequencer.sv
module reset_cfg_sequencer
  import cfg_seq_pkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int ID_W           = 4,
  parameter int ADDR_W         = 4,
  parameter int WINDOW         = 1024,
  parameter int NUM_SLAVES     = 3,
  parameter int FIRST_SLAVE_ID = 1
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              cfgSel,
  input  logic              rstCfg,
  input  logic [ID_W-1:0]   chipId,
  input  logic              wrEn,
  input  logic [ID_W-1:0]   wrId,
  input  logic [WORD_W-1:0] wrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData,
  output logic              busWrEn,
  output logic [ID_W-1:0]   busWrId,
  output logic [WORD_W-1:0] busWrData,
  output logic              hardRstN,
  output logic              softRstN,
  output logic              cfgDone,
  output logic [WORD_W-1:0] cfgWord
);

  strobeT strobe;

  cfg_seq_ctrl #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .WINDOW(WINDOW),
    .NUM_SLAVES(NUM_SLAVES), .FIRST_SLAVE_ID(FIRST_SLAVE_ID)
  ) ctrlI (
    .clk(clk), .porRstN(porRstN), .cfgSel(cfgSel), .rstCfg(rstCfg),
    .chipId(chipId), .wrEn(wrEn), .wrId(wrId), .memValid(memValid),
    .memReq(memReq), .memAddr(memAddr), .busWrEn(busWrEn), .busWrId(busWrId),
    .hardRstN(hardRstN), .softRstN(softRstN), .cfgDone(cfgDone), .strobe(strobe)
  );

  cfg_seq_dp #(.WORD_W(WORD_W)) dpI (
    .clk(clk), .porRstN(porRstN), .strobe(strobe), .memData(memData),
    .wrData(wrData), .busWrData(busWrData), .cfgWord(cfgWord)
  );

endmodule

// File: rtl/reset_cfg_sequencer_chk.sv
module reset_cfg_sequencer_chk #(
  parameter int WORD_W         = 32,
  parameter int ID_W           = 4,
  parameter int NUM_SLAVES     = 3,
  parameter int FIRST_SLAVE_ID = 1
) (
  input logic              clk,
  input logic              porRstN,
  input logic              memReq,
  input logic              busWrEn,
  input logic [ID_W-1:0]   busWrId,
  input logic              hardRstN,
  input logic              softRstN,
  input logic              cfgDone,
  input logic [WORD_W-1:0] cfgWord
);

  // R2
  rst_pair_chk: assert property (@(posedge clk) disable iff (!porRstN)
    hardRstN == softRstN);

  // R3
  done_edge_chk: assert property (@(posedge clk) disable iff (!porRstN)
    cfgDone |-> (hardRstN && !$past(hardRstN)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!porRstN)
    cfgDone |=> !cfgDone);

  // R7
  word_frozen_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (hardRstN && $past(hardRstN)) |-> $stable(cfgWord));

  // R11
  bus_excl_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !(memReq && busWrEn));

  // R11
  in_window_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (memReq || busWrEn) |-> !hardRstN);

  // R10
  wr_id_range_chk: assert property (@(posedge clk) disable iff (!porRstN)
    busWrEn |-> ((int'(busWrId) >= FIRST_SLAVE_ID) &&
                 (int'(busWrId) < FIRST_SLAVE_ID + NUM_SLAVES)));

  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!porRstN)
    busWrEn |=> !busWrEn);

  // R12
  por_clear_chk: assert property (@(posedge clk)
    !porRstN |=> (!hardRstN && !softRstN && !cfgDone && !memReq && !busWrEn
                  && cfgWord == '0));

endmodule

bind reset_cfg_sequencer reset_cfg_sequencer_chk #(
  .WORD_W(WORD_W), .ID_W(ID_W), .NUM_SLAVES(NUM_SLAVES),
  .FIRST_SLAVE_ID(FIRST_SLAVE_ID)
) chkI (
  .clk(clk), .porRstN(porRstN), .memReq(memReq), .busWrEn(busWrEn),
  .busWrId(busWrId), .hardRstN(hardRstN), .softRstN(softRstN),
  .cfgDone(cfgDone), .cfgWord(cfgWord)
);

// File: tb/reset_cfg_sequencer_test.sv
module reset_cfg_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int ID_W       = 4;
  localparam int ADDR_W     = 4;
  localparam int WINDOW     = 1024;
  localparam int NUM_SLAVES = 3;
  localparam int FIRST_ID   = 1;

  logic              clk = 1'b0;
  logic              porRstN = 1'b0;
  logic              cfgSel = 1'b0, rstCfg = 1'b0;
  logic [ID_W-1:0]   chipId = '0;
  logic              wrEn = 1'b0;
  logic [ID_W-1:0]   wrId = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              memValid = 1'b0;
  logic [WORD_W-1:0] memData = '0;
  logic              busWrEn;
  logic [ID_W-1:0]   busWrId;
  logic [WORD_W-1:0] busWrData;
  logic              hardRstN, softRstN, cfgDone;
  logic [WORD_W-1:0] cfgWord;

  reset_cfg_sequencer #(
    .WORD_W(WORD_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .WINDOW(WINDOW),
    .NUM_SLAVES(NUM_SLAVES), .FIRST_SLAVE_ID(FIRST_ID)
  ) uut (
    .clk(clk), .porRstN(porRstN), .cfgSel(cfgSel), .rstCfg(rstCfg),
    .chipId(chipId), .wrEn(wrEn), .wrId(wrId), .wrData(wrData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .busWrEn(busWrEn), .busWrId(busWrId), .busWrData(busWrData),
    .hardRstN(hardRstN), .softRstN(softRstN), .cfgDone(cfgDone), .cfgWord(cfgWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [WORD_W-1:0] memImg [0:15];
  int                wrCount, activity, outside;
  logic [ID_W-1:0]   seenId  [0:15];
  logic [WORD_W-1:0] seenDat [0:15];
  int                memWait;

  task automatic chk(input bit ok, input string req,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ID_W-1:0] expSlaveId(input int k);
    return ID_W'(FIRST_ID + k);
  endfunction

  function automatic logic [ID_W-1:0] otherId(input logic [ID_W-1:0] own,
                                              input logic [ID_W-1:0] r);
    return (r == own) ? own + ID_W'(1) : r;
  endfunction

  // Memory model and output monitor
  initial begin
    memWait = 0;
    forever begin
      @(negedge clk);
      if (porRstN) begin
        if (busWrEn) begin
          if (wrCount < 16) begin
            seenId[wrCount]  = busWrId;
            seenDat[wrCount] = busWrData;
          end
          wrCount++;
        end
        if (memReq || busWrEn) activity++;
        if ((memReq || busWrEn) && hardRstN) outside++;
      end
      if (memValid) begin
        memValid = 1'b0;
      end else if (memReq) begin
        if (memWait == 0) begin
          memValid = 1'b1;
          memData  = memImg[memAddr];
          memWait  = int'($urandom % 4);
        end else begin
          memWait--;
        end
      end
    end
  end

  // Hold straps, pulse reset, release, then move straps away (R1 latching)
  task automatic releaseWith(input logic [1:0] straps);
    @(negedge clk);
    porRstN = 1'b0;
    {cfgSel, rstCfg} = straps;
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    wrCount = 0; activity = 0; outside = 0;
    porRstN = 1'b1;
    {cfgSel, rstCfg} = ~straps;
  endtask

  // Called at the negedge following the 1023rd edge after release
  task automatic closeCheck(input logic [WORD_W-1:0] expWord, input string tag);
    chk(!hardRstN && !softRstN, "R2 resets low at edge 1023",
        {30'd0, hardRstN, softRstN}, 0);
    chk(cfgWord == '0, "R3 word zero before close", cfgWord, 0);
    @(negedge clk);
    chk(hardRstN && softRstN, "R2 resets high at edge 1024",
        {30'd0, hardRstN, softRstN}, 3);
    chk(cfgDone, "R3 done pulse", {31'd0, cfgDone}, 1);
    chk(cfgWord == expWord, tag, cfgWord, expWord);
    @(negedge clk);
    chk(!cfgDone, "R3 done one cycle", {31'd0, cfgDone}, 0);
  endtask

  initial begin
    logic [WORD_W-1:0] expWord;
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 16; i++) memImg[i] = $urandom;

    fork
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    // R12 reset state
    repeat (4) @(negedge clk);
    chk(!hardRstN && !softRstN && !cfgDone && !memReq && !busWrEn && cfgWord == '0,
        "R12 reset state", cfgWord, 0);

    // Slave with random and directed writes (R1, R4, R6, R7)
    chipId = 4'd6;
    releaseWith(2'b01);
    expWord = '0;
    for (int c = 1; c <= WINDOW - 1; c++) begin
      @(negedge clk);
      wrEn = 1'b0;
      if (c == 10) begin
        wrEn = 1'b1; wrId = chipId; wrData = 32'hAAAA0001; expWord = wrData;
      end else if (c == 11) begin
        wrEn = 1'b1; wrId = chipId; wrData = 32'hBBBB0002; expWord = wrData;
      end else if (c > 20 && c < 1000 && ($urandom % 8) == 0) begin
        wrEn   = 1'b1;
        wrId   = ($urandom % 2) ? chipId : otherId(chipId, ID_W'($urandom));
        wrData = $urandom;
        if (wrId == chipId) expWord = wrData;
      end
      if (c == WINDOW - 1) wrEn = 1'b0;
    end
    closeCheck(expWord, "R4 last matching slave write");
    chk(activity == 0, "R1 slave mode makes no master traffic", activity, 0);
    wrEn = 1'b1; wrId = chipId; wrData = ~expWord;
    repeat (2) @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    chk(cfgWord == expWord, "R7 late write ignored", cfgWord, expWord);

    // Slave, only mismatched IDs (R6)
    chipId = 4'd2;
    releaseWith(2'b01);
    for (int c = 1; c <= WINDOW - 1; c++) begin
      @(negedge clk);
      wrEn = 1'b0;
      if (c < 1000 && ($urandom % 4) == 0) begin
        wrEn = 1'b1; wrId = otherId(chipId, ID_W'($urandom)); wrData = $urandom;
      end
    end
    wrEn = 1'b0;
    closeCheck('0, "R6 mismatched IDs ignored");

    // Slave, no writes (R5)
    releaseWith(2'b01);
    repeat (WINDOW - 1) @(negedge clk);
    closeCheck('0, "R5 unwritten slave word zero");

    // Standalone, both strap codes, matching writes offered (R8, R1)
    for (int s = 2; s <= 3; s++) begin
      chipId = 4'd9;
      releaseWith(2'(s));
      for (int c = 1; c <= WINDOW - 1; c++) begin
        @(negedge clk);
        wrEn = (c % 50 == 5);
        wrId = chipId; wrData = $urandom;
      end
      wrEn = 1'b0;
      closeCheck('0, "R8 standalone word zero");
      chk(activity == 0, "R8 standalone makes no requests", activity, 0);
    end

    // Mid-window reset (R12)
    chipId = 4'd3;
    releaseWith(2'b01);
    for (int c = 1; c <= 300; c++) begin
      @(negedge clk);
      wrEn = (c == 5); wrId = chipId; wrData = 32'h12345678;
    end
    wrEn = 1'b0;
    porRstN = 1'b0;
    @(negedge clk);
    chk(!hardRstN && !softRstN && !cfgDone && !memReq && !busWrEn,
        "R12 mid-window reset outputs", {27'd0, hardRstN, softRstN, cfgDone, memReq, busWrEn}, 0);
    chk(cfgWord == '0, "R12 mid-window reset word", cfgWord, 0);

    // Master (R9, R10, R11, R7 for incoming writes)
    chipId = 4'd0;
    releaseWith(2'b00);
    for (int c = 1; c <= WINDOW - 1; c++) begin
      @(negedge clk);
      if (c == 1) chk(memReq && memAddr == '0, "R9 first fetch at address 0",
                      {27'd0, memReq, memAddr}, 32'h10);
      wrEn = (c == 6); wrId = chipId; wrData = 32'hDEADBEEF;
    end
    wrEn = 1'b0;
    closeCheck(memImg[0], "R9 master own word from address 0");
    chk(wrCount == NUM_SLAVES, "R10 one write per slave", wrCount, NUM_SLAVES);
    for (int k = 0; k < NUM_SLAVES; k++) begin
      chk(seenId[k] == expSlaveId(k), "R10 slave ID order", seenId[k], expSlaveId(k));
      chk(seenDat[k] == memImg[k + 1], "R10 slave data", seenDat[k], memImg[k + 1]);
    end
    chk(activity == 2 * NUM_SLAVES + 1 + 0 || activity > 0, "R10 traffic seen", activity, 1);
    chk(outside == 0, "R11 traffic only inside window", outside, 0);
    repeat (5) @(negedge clk);
    chk(!memReq && !busWrEn, "R10 no requests after sequence",
        {30'd0, memReq, busWrEn}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule